// File: doc/BRIEF.md
# FIFO-Threshold DMA Request Generator

This block raises one level-sensitive DMA request for a serial memory-card host. The host has two four-entry FIFOs of half-words, one for receive and one for transmit. The block compares the occupancy of the FIFO that serves the current packet command against a threshold, and asserts the request while that threshold is met. The request is qualified by an enable bit that software sets before it starts a transfer.

A small control register holds three bits: an enable, a receive-threshold select and a transmit-threshold select. A separate acknowledge-mode input decides whether the two select bits count. When acknowledge-mode is low, both thresholds fall back to the single-half-word form. For a read command, the request is driven from the receive count. For a write command, it is driven from the transmit count. With no command active, the request stays low.

The request is registered, so it follows its inputs with one clock of latency.

Top module: `dmareq_gen`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears all control bits. After that edge the register reads 16'h0000 and dma_req is 0.
- R2: When the enable bit (bit 15 of the control register) is 0, dma_req is 0 whatever the other inputs are.
- R3: With the receive threshold in effect at single-entry (the select bit at bit 4 is 0, or ack_mode is 0), a read command (cmd_active=1, cmd_is_read=1) asserts dma_req exactly when rx_level is 1 or more.
- R4: With ack_mode=1 and the receive select bit (bit 4) set to 1, a read command asserts dma_req only when rx_level equals 4 (full).
- R5: With the transmit threshold in effect at single-slot (the select bit at bit 0 is 0, or ack_mode is 0), a write command (cmd_active=1, cmd_is_read=0) asserts dma_req exactly when tx_level is below 4.
- R6: With ack_mode=1 and the transmit select bit (bit 0) set to 1, a write command asserts dma_req only when tx_level equals 0 (empty).
- R7: When ack_mode=0, the receive and transmit select bits have no effect, and the block behaves as if both were 0.
- R8: Only bits 15, 4 and 0 are stored. Writes to every other bit are discarded, and those bits read back as 0.
- R9: With cmd_active=0, dma_req is 0 whatever the FIFO levels are.
- R10: dma_req is registered. It takes the value computed from the inputs present at a clock edge, and holds it until the next edge, so it drops on the first edge after the level leaves the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 16 | Control register write data |
| cfg_rd_data | output | 16 | Control register readback |
| ack_mode | input | 1 | Acknowledge mode; enables the threshold select bits |
| cmd_active | input | 1 | A packet command is in progress |
| cmd_is_read | input | 1 | 1 = read command, 0 = write command |
| rx_level | input | 3 | Receive FIFO occupancy, 0 to 4 |
| tx_level | input | 3 | Transmit FIFO occupancy, 0 to 4 |
| dma_req | output | 1 | Registered DMA request |

## Verification
The main function is tried with the receive and transmit levels placed just inside and just outside each threshold, under each combination of select bit and ack_mode. Setting a select bit with ack_mode low tells a correct fallback apart from a design that honours the select bits unconditionally. Vectors in which the FIFO not selected by the command sits at a level that would assert the request show that the command direction picks the right counter. An idle command and a cleared enable, each with both FIFOs at extreme levels, separate proper gating from threshold logic that merely happens to be false.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
    localparam int unsigned CFG_W     = 16;
    localparam int unsigned EN_BIT    = 15;
    localparam int unsigned RXSEL_BIT = 4;
    localparam int unsigned TXSEL_BIT = 0;

    typedef struct packed {
        logic enable;
        logic rx_full_mode;
        logic tx_empty_mode;
    } dma_ctrl_t;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_READ  = 2'd1,
        DIR_WRITE = 2'd2
    } xfer_dir_e;

    function automatic dma_ctrl_t ctrl_from_word(input logic [CFG_W-1:0] w);
        dma_ctrl_t c;
        c.enable        = w[EN_BIT];
        c.rx_full_mode  = w[RXSEL_BIT];
        c.tx_empty_mode = w[TXSEL_BIT];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] word_from_ctrl(input dma_ctrl_t c);
        logic [CFG_W-1:0] w;
        w            = '0;
        w[EN_BIT]    = c.enable;
        w[RXSEL_BIT] = c.rx_full_mode;
        w[TXSEL_BIT] = c.tx_empty_mode;
        return w;
    endfunction

    function automatic xfer_dir_e decode_dir(input logic active, input logic is_read);
        if (!active) return DIR_IDLE;
        return is_read ? DIR_READ : DIR_WRITE;
    endfunction
endpackage

// File: rtl/dmareq_ctrl_reg.sv
module dmareq_ctrl_reg
    import dmareq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output dma_ctrl_t        ctrl,
    output logic [CFG_W-1:0] rd_data
);
    dma_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_from_word(wr_data);
        end
    end

    assign ctrl    = ctrl_q;
    assign rd_data = word_from_ctrl(ctrl_q);
endmodule

// File: rtl/dmareq_threshold.sv
module dmareq_threshold
    import dmareq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  dma_ctrl_t        ctrl,
    input  logic             ack_mode,
    input  xfer_dir_e        dir,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    output logic             want_req
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic rx_strict;
    logic tx_strict;
    logic rx_hit;
    logic tx_hit;

    always_comb begin
        rx_strict = ack_mode & ctrl.rx_full_mode;
        tx_strict = ack_mode & ctrl.tx_empty_mode;
        rx_hit    = rx_strict ? (rx_level == FULL_LVL) : (rx_level != '0);
        tx_hit    = tx_strict ? (tx_level == '0) : (tx_level < FULL_LVL);
        unique case (dir)
            DIR_READ:  want_req = ctrl.enable & rx_hit;
            DIR_WRITE: want_req = ctrl.enable & tx_hit;
            default:   want_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmareq_gen.sv
module dmareq_gen
    import dmareq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [15:0]      cfg_wr_data,
    output logic [15:0]      cfg_rd_data,
    input  logic             ack_mode,
    input  logic             cmd_active,
    input  logic             cmd_is_read,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    output logic             dma_req
);
    dma_ctrl_t ctrl;
    xfer_dir_e dir;
    logic      want_req;
    logic      req_q;

    dmareq_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .ctrl    (ctrl),
        .rd_data (cfg_rd_data)
    );

    assign dir = decode_dir(cmd_active, cmd_is_read);

    dmareq_threshold #(.DEPTH(DEPTH)) u_thr (
        .ctrl     (ctrl),
        .ack_mode (ack_mode),
        .dir      (dir),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .want_req (want_req)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= want_req;
    end

    assign dma_req = req_q;
endmodule

// File: rtl/dmareq_gen_chk.sv
module dmareq_gen_chk #(
    parameter int unsigned LVL_W = 3,
    parameter int unsigned DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      cfg_rd_data,
    input logic             ack_mode,
    input logic             cmd_active,
    input logic             cmd_is_read,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic             dma_req
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cfg_rd_data == 16'h0000) && !dma_req);

    a_r2_enable_gate: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd_data[15] |=> !dma_req);

    a_r3_rx_single: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[15] && cmd_active && cmd_is_read &&
         !(ack_mode && cfg_rd_data[4]) && rx_level != '0) |=> dma_req);

    a_r4_rx_full_only: assert property (@(posedge clk) disable iff (rst)
        (cmd_active && cmd_is_read && ack_mode && cfg_rd_data[4] &&
         rx_level != FULL_LVL) |=> !dma_req);

    a_r6_tx_empty_only: assert property (@(posedge clk) disable iff (rst)
        (cmd_active && !cmd_is_read && ack_mode && cfg_rd_data[0] &&
         tx_level != '0) |=> !dma_req);

    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        !cmd_active |=> !dma_req);

    always @(negedge clk) begin
        if (!rst) begin
            a_r8_reserved_zero: assert ((cfg_rd_data & 16'h7FEE) == 16'h0000);
        end
    end
endmodule

bind dmareq_gen dmareq_gen_chk #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_rd_data (cfg_rd_data),
    .ack_mode    (ack_mode),
    .cmd_active  (cmd_active),
    .cmd_is_read (cmd_is_read),
    .rx_level    (rx_level),
    .tx_level    (tx_level),
    .dma_req     (dma_req)
);

// File: tb/sim_dmareq_gen.sv
`timescale 1ns/1ps
module sim_dmareq_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic [15:0] cfg_rd_data;
    logic        ack_mode = 1'b0;
    logic        cmd_active = 1'b0;
    logic        cmd_is_read = 1'b0;
    logic [2:0]  rx_level = '0;
    logic [2:0]  tx_level = '0;
    logic        dma_req;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dmareq_gen u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .ack_mode(ack_mode), .cmd_active(cmd_active),
        .cmd_is_read(cmd_is_read), .rx_level(rx_level), .tx_level(tx_level),
        .dma_req(dma_req)
    );

    // {en, rxsel, txsel, ack, active, read, rx[2:0], tx[2:0], expected}
    localparam int NV = 15;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_0_0_0_1_1_100_000_0,  // R2 enable off
        13'b1_0_0_0_1_1_000_000_0,  // R3 rx empty
        13'b1_0_0_0_1_1_001_100_1,  // R3 rx one entry
        13'b1_1_0_1_1_1_011_000_0,  // R4 rx three, full needed
        13'b1_1_0_1_1_1_100_100_1,  // R4 rx full
        13'b1_1_0_0_1_1_001_100_1,  // R7 rx select ignored
        13'b1_0_0_1_1_1_010_100_1,  // R3 ack on, select off
        13'b1_0_0_0_1_0_000_100_0,  // R5 tx full
        13'b1_0_0_0_1_0_100_011_1,  // R5 one slot free
        13'b1_0_1_1_1_0_000_001_0,  // R6 tx not empty
        13'b1_0_1_1_1_0_000_000_1,  // R6 tx empty
        13'b1_0_1_0_1_0_000_010_1,  // R7 tx select ignored
        13'b1_0_0_0_0_1_100_000_0,  // R9 idle
        13'b1_0_0_0_0_0_100_000_0,  // R9 idle write flag
        13'b1_0_0_0_1_0_100_100_0   // R5 rx level ignored on write
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cfg", cfg_rd_data, 16'h0000);
        check("R1 req", {15'd0, dma_req}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            write_cfg({VEC[i][12], 10'd0, VEC[i][11], 3'd0, VEC[i][10]});
            ack_mode    = VEC[i][9];
            cmd_active  = VEC[i][8];
            cmd_is_read = VEC[i][7];
            rx_level    = VEC[i][6:4];
            tx_level    = VEC[i][3:1];
            @(negedge clk);
            check($sformatf("R2-7,9 vector %0d", i), {15'd0, dma_req}, {15'd0, VEC[i][0]});
        end

        // R8: reserved bits discarded
        write_cfg(16'hFFFF);
        check("R8 all ones", cfg_rd_data, 16'h8011);
        write_cfg(16'h7FEE);
        check("R8 reserved only", cfg_rd_data, 16'h0000);

        // R10: one-clock latency on drop
        write_cfg(16'h8000);
        ack_mode = 1'b0; cmd_active = 1'b1; cmd_is_read = 1'b1;
        rx_level = 3'd1; tx_level = 3'd4;
        @(negedge clk);
        check("R10 asserted", {15'd0, dma_req}, 16'd1);
        rx_level = 3'd0;
        #1;
        check("R10 held before edge", {15'd0, dma_req}, 16'd1);
        @(negedge clk);
        check("R10 dropped after edge", {15'd0, dma_req}, 16'd0);

        // R1: mid-run reset clears control and request
        rx_level = 3'd2;
        @(negedge clk);
        check("R10 reasserted", {15'd0, dma_req}, 16'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid cfg", cfg_rd_data, 16'h0000);
        check("R1 mid req", {15'd0, dma_req}, 16'd0);
        @(negedge clk);
        check("R2 after reset", {15'd0, dma_req}, 16'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule